// File: doc/BRIEF.md
# Diagnostic RAM Dump Serializer

This block runs the diagnostic dump of a keyboard controller. When the command decoder raises `start`, it first copies the live port state into four scratch locations of the controller RAM. It then reads a window of RAM locations one at a time and turns each byte into three keystroke codes: the upper hex digit, the lower hex digit, and a space. These codes are meant to be shown by the host's console as if they had been typed.

Each code is offered on `out_byte` with `out_valid` high. The block holds the code until the host reads it, which `host_rd` signals, and it waits as long as that takes. A write to the command port stops the dump at once. While a dump is running the keyboard link is held off through `kbd_inhibit`. The RAM sits outside the block. The block reaches it through a synchronous port that returns read data one cycle after the address.

Top module: `diag_dump_serializer`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid`, `ram_we`, `done`, `aborted` and `kbd_inhibit` are all low.
- R2: After `start`, the block writes `p1_in` to RAM address 30h and `p2_in` to 31h before it offers any output byte.
- R3: RAM address 32h receives `t0_in` in bit 0 and `t1_in` in bit 1, with bits 7..2 written as zero.
- R4: RAM address 33h receives `psw_in`.
- R5: The block sends addresses 20h to 33h in ascending order, 60 codes in all. For each address it sends three codes: first the code of bits 7..4, then the code of bits 3..0, then the space code 39h.
- R6: The hex digit code is 0Bh for digit 0. Digits 1 to 9 map to 02h to 0Ah. The letters A, B, C, D, E and F map to 1Eh, 30h, 2Eh, 20h, 12h and 21h.
- R7: While `out_valid` is high and `host_rd` is low, `out_byte` and `out_valid` hold their values, however long the host waits.
- R8: When `cmd_wr` is high on a clock edge while `busy` is high, then after that edge `busy` and `out_valid` are low and `aborted` is high for exactly one cycle.
- R9: `done` is high for exactly one cycle, right after the edge on which the host reads the last space code (the one for address 33h). `aborted` stays low on a dump that finishes normally.
- R10: `kbd_inhibit` is high from the edge that accepts `start` until the dump ends, and low when the block is idle.
- R11: A `start` pulse while `busy` is high has no effect: the code on offer and the rest of the sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Dump command accepted by the decoder (one-cycle pulse) |
| cmd_wr | input | 1 | Host wrote the command port; aborts a running dump |
| host_rd | input | 1 | Host read the current output code |
| p1_in | input | 8 | Live input port value |
| p2_in | input | 8 | Live output port value |
| t0_in | input | 1 | Test input 0 |
| t1_in | input | 1 | Test input 1 |
| psw_in | input | 8 | Status word to snapshot |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM address for reads and writes |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after address |
| out_valid | output | 1 | A code is waiting for the host |
| out_byte | output | 8 | The code on offer |
| busy | output | 1 | A dump is in progress |
| kbd_inhibit | output | 1 | Hold off keyboard input |
| done | output | 1 | One-cycle pulse when the dump completes |
| aborted | output | 1 | One-cycle pulse when the dump is cut short |

## Verification
The hardest case to reach is an abort at a chosen point deep in the stream, for example in the middle of a digit pair or during the snapshot writes. At those points the state is transient or depends on the host's pace. The bench drives the host side itself, so it counts codes read and fires `cmd_wr` at exact positions, including the cycle right after `start`. Full dumps run with varying host delays and a spurious `start` injected mid-stream. Port values sweep the four test-input combinations, and the preset RAM covers every hex digit in both nibbles.

// File: rtl/dump_pkg.sv
package dump_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SNAP  = 3'd1,
      ST_ADDR  = 3'd2,
      ST_LATCH = 3'd3,
      ST_SEND  = 3'd4
   } dump_state_e;

   // nibble to scan set 1 make code of the matching key
   function automatic logic [7:0] hex_to_scan(input logic [3:0] nib);
      logic [7:0] code;
      if (nib == 4'h0)       code = 8'h0B;
      else if (nib <= 4'h9)  code = {4'h0, nib} + 8'h01;
      else begin
         case (nib)
            4'hA:    code = 8'h1E;
            4'hB:    code = 8'h30;
            4'hC:    code = 8'h2E;
            4'hD:    code = 8'h20;
            4'hE:    code = 8'h12;
            default: code = 8'h21;
         endcase
      end
      return code;
   endfunction

endpackage

// File: rtl/dump_snapshot.sv
module dump_snapshot #(
   parameter int ADDR_W    = 6,
   parameter int SNAP_ADDR = 'h30
) (
   input  logic [1:0]        idx,
   input  logic [7:0]        p1_in,
   input  logic [7:0]        p2_in,
   input  logic              t0_in,
   input  logic              t1_in,
   input  logic [7:0]        psw_in,
   output logic [ADDR_W-1:0] snap_addr,
   output logic [7:0]        snap_data
);
   localparam logic [ADDR_W-1:0] SNAP_BASE = ADDR_W'(SNAP_ADDR);

   always_comb begin
      snap_addr = SNAP_BASE + ADDR_W'(idx);
      case (idx)
         2'd0:    snap_data = p1_in;
         2'd1:    snap_data = p2_in;
         2'd2:    snap_data = {6'b0, t1_in, t0_in};
         default: snap_data = psw_in;
      endcase
   end
endmodule

// File: rtl/dump_encoder.sv
module dump_encoder
   import dump_pkg::*;
#(
   parameter logic [7:0] SPACE_CODE = 8'h39
) (
   input  logic [7:0] data,
   input  logic [1:0] phase,
   output logic [7:0] code
);
   logic [7:0] nib_code [2];

   for (genvar g = 0; g < 2; g++) begin : g_nib
      assign nib_code[g] = hex_to_scan(data[g*4 +: 4]);
   end

   always_comb begin
      case (phase)
         2'd0:    code = nib_code[1];
         2'd1:    code = nib_code[0];
         default: code = SPACE_CODE;
      endcase
   end
endmodule

// File: rtl/dump_sequencer.sv
module dump_sequencer
   import dump_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int BASE_ADDR = 'h20,
   parameter int LAST_ADDR = 'h33
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd_wr,
   input  logic              host_rd,
   input  logic [7:0]        ram_rdata,
   output dump_state_e       state,
   output logic [1:0]        snap_idx,
   output logic [ADDR_W-1:0] addr_q,
   output logic [1:0]        phase,
   output logic [7:0]        data_q,
   output logic              done,
   output logic              aborted
);
   localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(LAST_ADDR);
   localparam logic [1:0]        SPACE_PH = 2'd2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         snap_idx <= '0;
         addr_q   <= FIRST;
         phase    <= '0;
         data_q   <= '0;
         done     <= 1'b0;
         aborted  <= 1'b0;
      end else begin
         done    <= 1'b0;
         aborted <= 1'b0;
         if (cmd_wr && state != ST_IDLE) begin
            state   <= ST_IDLE;
            aborted <= 1'b1;
         end else begin
            case (state)
               ST_IDLE: if (start) begin
                  state    <= ST_SNAP;
                  snap_idx <= '0;
                  addr_q   <= FIRST;
               end
               ST_SNAP: begin
                  snap_idx <= snap_idx + 2'd1;
                  if (snap_idx == 2'd3) state <= ST_ADDR;
               end
               ST_ADDR:  state <= ST_LATCH;
               ST_LATCH: begin
                  data_q <= ram_rdata;
                  phase  <= '0;
                  state  <= ST_SEND;
               end
               ST_SEND: if (host_rd) begin
                  if (phase == SPACE_PH) begin
                     if (addr_q == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                     end else begin
                        addr_q <= addr_q + 1'b1;
                        state  <= ST_ADDR;
                     end
                  end else begin
                     phase <= phase + 2'd1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/diag_dump_serializer.sv
module diag_dump_serializer
   import dump_pkg::*;
#(
   parameter int         ADDR_W     = 6,
   parameter int         BASE_ADDR  = 'h20,
   parameter int         SNAP_ADDR  = 'h30,
   parameter logic [7:0] SPACE_CODE = 8'h39
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd_wr,
   input  logic              host_rd,
   input  logic [7:0]        p1_in,
   input  logic [7:0]        p2_in,
   input  logic              t0_in,
   input  logic              t1_in,
   input  logic [7:0]        psw_in,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   output logic              busy,
   output logic              kbd_inhibit,
   output logic              done,
   output logic              aborted
);
   localparam int LAST_ADDR = SNAP_ADDR + 3;

   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_width
      $error("snapshot window does not fit in ADDR_W");
   end
   if (BASE_ADDR > SNAP_ADDR) begin : g_bad_order
      $error("dump base must not lie above the snapshot area");
   end

   dump_state_e       state;
   logic [1:0]        snap_idx;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] snap_addr;
   logic [1:0]        phase;
   logic [7:0]        data_q;
   logic [7:0]        snap_data;

   dump_sequencer #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .LAST_ADDR(LAST_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_wr(cmd_wr),
      .host_rd(host_rd), .ram_rdata(ram_rdata), .state(state),
      .snap_idx(snap_idx), .addr_q(addr_q), .phase(phase),
      .data_q(data_q), .done(done), .aborted(aborted)
   );

   dump_snapshot #(.ADDR_W(ADDR_W), .SNAP_ADDR(SNAP_ADDR)) u_snap (
      .idx(snap_idx), .p1_in(p1_in), .p2_in(p2_in), .t0_in(t0_in),
      .t1_in(t1_in), .psw_in(psw_in), .snap_addr(snap_addr),
      .snap_data(snap_data)
   );

   dump_encoder #(.SPACE_CODE(SPACE_CODE)) u_enc (
      .data(data_q), .phase(phase), .code(out_byte)
   );

   assign busy        = (state != ST_IDLE);
   assign kbd_inhibit = busy;
   assign out_valid   = (state == ST_SEND);
   assign ram_we      = (state == ST_SNAP);
   assign ram_addr    = ram_we ? snap_addr : addr_q;
   assign ram_wdata   = snap_data;
endmodule

// File: rtl/diag_dump_checker.sv
module diag_dump_checker #(
   parameter int ADDR_W    = 6,
   parameter int SNAP_ADDR = 'h30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              cmd_wr,
   input logic              host_rd,
   input logic              busy,
   input logic              kbd_inhibit,
   input logic              out_valid,
   input logic [7:0]        out_byte,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              done,
   input logic              aborted
);
   localparam logic [ADDR_W-1:0] SNAP_LO = ADDR_W'(SNAP_ADDR);
   localparam logic [ADDR_W-1:0] SNAP_HI = ADDR_W'(SNAP_ADDR + 3);

   // R7
   hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !host_rd && !cmd_wr |=> out_valid && $stable(out_byte));

   // R8
   abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_wr |=> !busy && !out_valid && aborted);

   // R2
   snap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && !cmd_wr |=> ram_we && ram_addr == SNAP_LO);

   // R3
   write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_addr >= SNAP_LO && ram_addr <= SNAP_HI && !out_valid);

   // R9
   end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && aborted));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   inhibit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !kbd_inhibit);
endmodule

bind diag_dump_serializer diag_dump_checker #(
   .ADDR_W(ADDR_W), .SNAP_ADDR(SNAP_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cmd_wr(cmd_wr),
   .host_rd(host_rd), .busy(busy), .kbd_inhibit(kbd_inhibit),
   .out_valid(out_valid), .out_byte(out_byte), .ram_we(ram_we),
   .ram_addr(ram_addr), .done(done), .aborted(aborted)
);

// File: tb/diag_dump_serializer_test.sv
module diag_dump_serializer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, cmd_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] p1_in = '0, p2_in = '0, psw_in = '0;
   logic t0_in = 1'b0, t1_in = 1'b0;
   logic ram_we, out_valid, busy, kbd_inhibit, done, aborted;
   logic [5:0] ram_addr;
   logic [7:0] ram_wdata, out_byte;
   logic [7:0] ram_rdata = '0;
   logic [7:0] mem [64];
   logic [7:0] exp_mem [64];
   int total = 0, bad = 0;
   int cycles = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   diag_dump_serializer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_wr(cmd_wr),
      .host_rd(host_rd), .p1_in(p1_in), .p2_in(p2_in), .t0_in(t0_in),
      .t1_in(t1_in), .psw_in(psw_in), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .out_valid(out_valid), .out_byte(out_byte), .busy(busy),
      .kbd_inhibit(kbd_inhibit), .done(done), .aborted(aborted)
   );

   always_ff @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
   end

   function automatic logic [7:0] exp_code(input logic [3:0] n);
      logic [7:0] keys [6] = '{8'h1E, 8'h30, 8'h2E, 8'h20, 8'h12, 8'h21};
      if (n == 0) return 8'h0B;
      if (n < 10) return 8'(n) + 8'd1;
      return keys[n - 10];
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_valid();
      while (!out_valid) @(negedge clk);
   endtask

   task automatic read_one();
      host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
   endtask

   // full dump with host delays; poke = spurious start mid-stream (R11)
   task automatic full_dump(input logic [7:0] a, input logic [7:0] b,
                            input logic ta, input logic tb,
                            input logic [7:0] w, input bit poke);
      p1_in = a; p2_in = b; t0_in = ta; t1_in = tb; psw_in = w;
      for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
      exp_mem[6'h30] = a; exp_mem[6'h31] = b;
      exp_mem[6'h32] = {6'b0, tb, ta}; exp_mem[6'h33] = w;
      pulse_start();
      check("R10 inhibit during dump", kbd_inhibit, 1);
      for (int ad = 6'h20; ad <= 6'h33; ad++) begin
         for (int k = 0; k < 3; k++) begin
            logic [7:0] e;
            e = (k == 0) ? exp_code(exp_mem[ad][7:4]) :
                (k == 1) ? exp_code(exp_mem[ad][3:0]) : 8'h39;
            wait_valid();
            for (int d = 0; d < (ad + k) % 4; d++) @(negedge clk);
            if (poke && ad == 6'h25 && k == 1) begin
               start = 1'b1; @(negedge clk); start = 1'b0;
               @(negedge clk);
               check("R11 start while busy ignored", out_valid, 1);
            end
            check($sformatf("R5 R6 R7 code addr %0h part %0d", ad, k),
                  {out_valid, out_byte}, {1'b1, e});
            if (ad == 6'h33 && k == 2) begin
               host_rd = 1'b1;
               @(negedge clk); host_rd = 1'b0;
               check("R9 done pulse", {done, aborted, busy}, 3'b100);
               @(negedge clk);
               check("R9 done single cycle", done, 0);
               check("R10 inhibit released", kbd_inhibit, 0);
            end else begin
               read_one();
            end
         end
      end
      check("R2 P1 at 30h", mem[6'h30], a);
      check("R2 P2 at 31h", mem[6'h31], b);
      check("R3 test bits at 32h", mem[6'h32], {6'b0, tb, ta});
      check("R4 status word at 33h", mem[6'h33], w);
   endtask

   task automatic abort_after(input int nreads);
      pulse_start();
      for (int i = 0; i < nreads; i++) begin
         wait_valid(); read_one();
      end
      cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      check($sformatf("R8 abort after %0d reads", nreads),
            {busy, out_valid, aborted, done}, 4'b0010);
      @(negedge clk);
      check("R8 abort single cycle", {aborted, kbd_inhibit}, 2'b00);
      repeat (5) @(negedge clk);
      check("R8 stays idle", out_valid, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'((i * 8'h1B) ^ 8'h5A);
      for (int i = 0; i < 16; i++) mem[6'h20 + i] = {4'(i), 4'(15 - i)};
      repeat (3) @(negedge clk);
      check("R1 reset idle",
            {busy, out_valid, ram_we, done, aborted, kbd_inhibit}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset release", {busy, out_valid}, 2'b00);
      full_dump(8'hA5, 8'h3C, 1'b0, 1'b0, 8'hF0, 0);
      full_dump(8'h01, 8'hFE, 1'b1, 1'b0, 8'h96, 1);
      full_dump(8'h7E, 8'h81, 1'b0, 1'b1, 8'h0D, 0);
      full_dump(8'hBC, 8'h42, 1'b1, 1'b1, 8'hE7, 0);
      abort_after(0);
      abort_after(1);
      abort_after(4);
      abort_after(59);
      // abort during snapshot writes
      p1_in = 8'h11;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      check("R8 abort during snapshot", {busy, aborted}, 2'b01);
      full_dump(8'h5A, 8'hC3, 1'b1, 1'b0, 8'h2B, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule